// File: doc/BRIEF.md
# Up/Down Counter PWM Channel Bank

This block drives a bank of pulse-width-modulated logic outputs from one shared reflected counter. The counter starts at its top value, steps down once per enabled clock to zero, turns round and steps back up to the top, and repeats. Each channel keeps its own latched duty byte. A channel output flips whenever the count equals the bitwise inverse of that byte. The count passes that value once going down and once coming up, so the output is high for a window centred on the count-zero point. The window grows with the inverse of the byte.

A blank input acts asynchronously. It returns the counter to its top value, clears every latched byte and drives all outputs low. Channel bytes are latched together only at the top turnaround, so a write in mid-cycle never splits a pulse. The two counter extremes each appear for a single clock. A byte whose inverse is an extreme therefore gets only one match per cycle, and that match is ignored.

Top module: `pwm_bank`

## Requirements
- R1: While `blank` is high, every `pwm_out` bit is 0. This takes effect at once, without a clock edge. After release, the counter restarts at its top value (all ones).
- R2: With `enable` high, the counter moves by exactly one on each clock. After `blank` is released it first counts downward from the top value.
- R3: The counter reverses at 0 and at the top value, and each extreme lasts exactly one clock. A full cycle is 2*(2^CNT_W - 1) enabled clocks, which is 510 for CNT_W = 8.
- R4: While `enable` is low, the counter and all outputs hold their values.
- R5: A channel output flips on the clock edge that follows a cycle in which the count equals the bitwise inverse of that channel's latched byte. For example, byte 8'hFD matches count 2.
- R6: For latched byte d with c = ~d strictly between 0 and the top value, the output is high for exactly 2*c enabled clocks in each counter cycle.
- R7: A channel byte is captured only on an enabled clock edge where the count is at the top value. A byte change at any other time takes effect from the next top turnaround.
- R8: A channel whose byte is 8'h00 or 8'hFF keeps its output low, because its single match falls on an extreme.
- R9: After `blank` is released with `enable` high, a channel with c = ~d first goes high after 2^CNT_W - c enabled edges. For CNT_W = 8 this is 256 - c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter and all channel registers |
| blank | input | 1 | Asynchronous clear, active high: counter to top, outputs low |
| enable | input | 1 | Advances the counter and allows output changes when high |
| ch_data | input | NUM_CH*CNT_W | Duty bytes; channel i occupies bits [i*CNT_W +: CNT_W] |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The counter is not visible at the ports, so its state is observed only through when the outputs rise and fall. A counter that repeats an extreme, skips a step or resumes in the wrong direction shifts the edges on every channel within one counter cycle, at most 510 clocks. A wrong latched byte shows as a wrong pulse width in the first cycle after the top turnaround. A missed suppression at an extreme shows on the extreme-valued channels as a stray high level that lasts until the next match.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
   typedef enum logic {
      CNT_DOWN = 1'b0,
      CNT_UP   = 1'b1
   } cnt_dir_e;

   localparam int unsigned MIN_CNT_W  = 2;
   localparam int unsigned MIN_NUM_CH = 1;
endpackage

// File: rtl/pwm_updown_counter.sv
`timescale 1ns/1ps
module pwm_updown_counter
   import pwm_bank_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             blank,
   input  logic             enable,
   output logic [CNT_W-1:0] count,
   output logic             at_top,
   output logic             at_bottom
);
   localparam logic [CNT_W-1:0] TOP_V     = '1;
   localparam logic [CNT_W-1:0] BOT_V     = '0;
   localparam logic [CNT_W-1:0] NEAR_TOP  = {{(CNT_W-1){1'b1}}, 1'b0};
   localparam logic [CNT_W-1:0] NEAR_BOT  = {{(CNT_W-1){1'b0}}, 1'b1};

   cnt_dir_e dir_q;

   always_ff @(posedge clk or posedge blank) begin
      if (blank) begin
         count <= TOP_V;
         dir_q <= CNT_DOWN;
      end else if (enable) begin
         if (dir_q == CNT_DOWN) begin
            count <= count - 1'b1;
            if (count == NEAR_BOT) dir_q <= CNT_UP;
         end else begin
            count <= count + 1'b1;
            if (count == NEAR_TOP) dir_q <= CNT_DOWN;
         end
      end
   end

   assign at_top    = (count == TOP_V);
   assign at_bottom = (count == BOT_V);

   p_step_r2: assert property (@(posedge clk) disable iff (blank)
      (enable && !at_top && !at_bottom) |=>
         ((count == CNT_W'($past(count) + 1'b1)) || (count == CNT_W'($past(count) - 1'b1))));

   p_turn_low_r3: assert property (@(posedge clk) disable iff (blank)
      (enable && at_bottom) |=> (count == NEAR_BOT));

   p_turn_high_r3: assert property (@(posedge clk) disable iff (blank)
      (enable && at_top) |=> (count == NEAR_TOP));

   p_hold_cnt_r4: assert property (@(posedge clk) disable iff (blank)
      !enable |=> $stable(count));
endmodule

// File: rtl/pwm_match_channel.sv
`timescale 1ns/1ps
module pwm_match_channel #(
   parameter int unsigned CNT_W          = 8,
   parameter bit          STORE_INVERTED = 1'b1
) (
   input  logic             clk,
   input  logic             blank,
   input  logic             enable,
   input  logic             load,
   input  logic             at_edge,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] data_in,
   output logic             pwm
);
   logic [CNT_W-1:0] stored_q;
   logic             equal;
   logic             hit;

   generate
      if (STORE_INVERTED) begin : g_inv_store
         always_ff @(posedge clk or posedge blank) begin
            if (blank)     stored_q <= '0;
            else if (load) stored_q <= ~data_in;
         end
         assign equal = (count == stored_q);
      end else begin : g_plain_store
         always_ff @(posedge clk or posedge blank) begin
            if (blank)     stored_q <= '1;
            else if (load) stored_q <= data_in;
         end
         assign equal = (count == ~stored_q);
      end
   endgenerate

   assign hit = enable & ~at_edge & equal;

   always_ff @(posedge clk or posedge blank) begin
      if (blank) pwm <= 1'b0;
      else       pwm <= pwm ^ hit;
   end

   p_hold_out_r4: assert property (@(posedge clk) disable iff (blank)
      !enable |=> $stable(pwm));

   p_extreme_quiet_r8: assert property (@(posedge clk) disable iff (blank)
      (enable && at_edge) |=> $stable(pwm));

   p_latch_at_top_r7: assert property (@(posedge clk) disable iff (blank)
      !load |=> $stable(stored_q));
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH         = 32,
   parameter int unsigned CNT_W          = 8,
   parameter bit          STORE_INVERTED = 1'b1
) (
   input  logic                    clk,
   input  logic                    blank,
   input  logic                    enable,
   input  logic [NUM_CH*CNT_W-1:0] ch_data,
   output logic [NUM_CH-1:0]       pwm_out
);
   localparam int unsigned BUS_W = NUM_CH * CNT_W;

   generate
      if (CNT_W < MIN_CNT_W) begin : g_bad_width
         initial $fatal(1, "pwm_bank: CNT_W must be at least %0d", MIN_CNT_W);
      end
      if (NUM_CH < MIN_NUM_CH) begin : g_bad_count
         initial $fatal(1, "pwm_bank: NUM_CH must be at least %0d", MIN_NUM_CH);
      end
      if (BUS_W != $bits(ch_data)) begin : g_bad_bus
         initial $fatal(1, "pwm_bank: data bus width mismatch");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic             at_top;
   logic             at_bottom;
   logic             at_edge;
   logic             load_now;

   pwm_updown_counter #(
      .CNT_W (CNT_W)
   ) counter_i (
      .clk       (clk),
      .blank     (blank),
      .enable    (enable),
      .count     (count),
      .at_top    (at_top),
      .at_bottom (at_bottom)
   );

   assign at_edge  = at_top | at_bottom;
   assign load_now = enable & at_top;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         pwm_match_channel #(
            .CNT_W          (CNT_W),
            .STORE_INVERTED (STORE_INVERTED)
         ) chan_i (
            .clk     (clk),
            .blank   (blank),
            .enable  (enable),
            .load    (load_now),
            .at_edge (at_edge),
            .count   (count),
            .data_in (ch_data[ch*CNT_W +: CNT_W]),
            .pwm     (pwm_out[ch])
         );
      end
   endgenerate

   p_restart_top_r2: assert property (@(posedge clk) disable iff (blank)
      $fell(blank) |-> at_top);
endmodule

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
   localparam int NCH  = 32;
   localparam int W    = 8;
   localparam int TOPV = 255;
   localparam int PER  = 2 * TOPV;

   logic clk = 1'b0;
   logic blank = 1'b1;
   logic enable = 1'b0;
   logic [NCH*W-1:0] ch_data = '0;
   logic [NCH-1:0]   pwm_out;

   pwm_bank #(.NUM_CH(NCH), .CNT_W(W)) dut_i (
      .clk(clk), .blank(blank), .enable(enable), .ch_data(ch_data), .pwm_out(pwm_out));

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int k = 0;
   int cyc = 0;
   bit sb_on = 1'b0;
   string tag = "R1";
   logic [W-1:0]   applied [NCH];
   logic [W-1:0]   eff [NCH];
   logic [NCH-1:0] expq [$];

   function automatic bit level_at(logic [W-1:0] d, int kk);
      logic [W-1:0] inv = ~d;
      int c = int'(inv);
      int p = kk % PER;
      if (c == 0 || c == TOPV) return 1'b0;
      return (p > TOPV - c) && (p <= TOPV + c);
   endfunction

   function automatic logic [NCH-1:0] expect_vec(int kk);
      logic [NCH-1:0] v = '0;
      for (int i = 0; i < NCH; i++) v[i] = level_at(eff[i], kk);
      return v;
   endfunction

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic check_vec(string t, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s k=%0d act=%h exp=%h", t, k, act, exp);
      end
   endtask

   task automatic check_int(string t, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s k=%0d act=%0d exp=%0d", t, k, act, exp);
      end
   endtask

   task automatic set_data(int ch, logic [W-1:0] v);
      applied[ch] = v;
      ch_data[ch*W +: W] = v;
   endtask

   task automatic wait_k(int n);
      while (k != n) @(negedge clk);
   endtask

   // driver side: reference sequence from the requirements, pushed per clock
   always @(posedge clk) begin
      if (blank) k = 0;
      else if (enable) begin
         if (k % PER == 0) for (int i = 0; i < NCH; i++) eff[i] = applied[i];
         k++;
      end
      if (sb_on) expq.push_back(expect_vec(k));
   end

   // monitor side: pops expectations and compares away from the active edge
   always @(negedge clk) begin
      logic [NCH-1:0] e;
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=done");
         finish_run();
      end
      if (expq.size() > 0) begin
         e = expq.pop_front();
         check_vec(tag, pwm_out, e);
      end
   end

   initial begin
      int hi [NCH];
      logic [NCH-1:0] snap;
      for (int i = 0; i < NCH; i++) begin
         set_data(i, W'(i * 37 + 11));
         eff[i] = '1;
      end
      set_data(0, 8'hFD);  // c = 2
      set_data(1, 8'h00);  // extreme
      set_data(2, 8'hFF);  // extreme
      set_data(3, 8'hFE);  // c = 1
      set_data(4, 8'h01);  // c = 254
      set_data(5, 8'h80);  // c = 127

      @(negedge clk);
      @(negedge clk);
      check_vec("R1 reset outputs low", pwm_out, '0);
      sb_on = 1'b1;
      @(negedge clk);

      #1 blank = 1'b0; enable = 1'b1; tag = "R2/R3/R5/R6/R9 scoreboard";

      wait_k(128);
      check_int("R9 ch5 low before first match", int'(pwm_out[5]), 0);
      wait_k(129);
      check_int("R9 ch5 first rise at 256-c", int'(pwm_out[5]), 1);
      wait_k(253);
      check_int("R5 ch0 low while count is 2", int'(pwm_out[0]), 0);
      wait_k(254);
      check_int("R5 ch0 flips after count 2", int'(pwm_out[0]), 1);
      wait_k(257);
      check_int("R6 ch0 still high", int'(pwm_out[0]), 1);
      wait_k(258);
      check_int("R6 ch0 falls after 2c", int'(pwm_out[0]), 0);

      wait_k(PER);
      for (int i = 0; i < NCH; i++) hi[i] = 0;
      for (int s = 0; s < PER; s++) begin
         for (int i = 0; i < NCH; i++) hi[i] += int'(pwm_out[i]);
         @(negedge clk);
      end
      check_int("R6 ch0 width", hi[0], 4);
      check_int("R8 ch1 byte 00 stays low", hi[1], 0);
      check_int("R8 ch2 byte FF stays low", hi[2], 0);
      check_int("R6 ch3 width", hi[3], 2);
      check_int("R6 ch4 width", hi[4], 508);
      check_int("R3 ch5 width one per cycle", hi[5], 254);

      wait_k(2 * PER + TOPV);
      snap = pwm_out;
      #1 enable = 1'b0; tag = "R4 pause scoreboard";
      repeat (20) @(negedge clk);
      check_vec("R4 outputs held", pwm_out, snap);
      #1 enable = 1'b1; tag = "R2/R3 resume scoreboard";

      wait_k(3 * PER + 100);
      #1 set_data(0, 8'hF0); set_data(3, 8'h7F); tag = "R7 scoreboard";
      wait_k(3 * PER + 255);
      check_int("R7 old byte still in use", int'(pwm_out[0]), 1);
      wait_k(4 * PER + 240);
      check_int("R7 new byte ch0 low", int'(pwm_out[0]), 0);
      wait_k(4 * PER + 241);
      check_int("R7 new byte ch0 rise", int'(pwm_out[0]), 1);

      wait_k(4 * PER + 255);
      check_int("R7 ch3 high mid window", int'(pwm_out[3]), 1);
      #1 blank = 1'b1;
      #0.5 check_vec("R1 async blank clears", pwm_out, '0);
      tag = "R1 blank scoreboard";
      repeat (3) @(negedge clk);
      #1 blank = 1'b0; tag = "R9 restart scoreboard";
      wait_k(240);
      check_int("R9 restart ch0 low", int'(pwm_out[0]), 0);
      wait_k(241);
      check_int("R9 restart ch0 first rise", int'(pwm_out[0]), 1);
      wait_k(300);

      sb_on = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule